// File: doc/BRIEF.md
# SPI Serial Memory with Write Protection

This block is an SPI slave in front of a byte-wide non-volatile store of 4096 locations, held here as an inferred RAM. A host selects it with an active-low chip select. It then shifts in an opcode, an optional 16-bit address and data, most significant bit first, and reads results back on the serial output. The host can read any length of data, read or change a small status byte, arm or disarm writes, and program up to one page of 32 bytes per transaction.

Programming is gated in three ways. A write-enable flag must be set before a write is accepted. A two-bit protection level in the status byte locks the top quarter, the top half or all of the array. A write-protect input, while low, blocks changes to the status byte. An accepted write starts a self-timed busy period of `BUSY_CYCLES` system clocks. During that period the status byte reports busy and new writes are refused. The serial pins are oversampled by the system clock, so SCK must stay well below a quarter of the clock rate.

Top module: `spi_prot_mem`

## Requirements
- R1: After reset the status byte reads 0x00, so busy, write-enable and protection level are all clear.
- R2: The status byte holds busy in bit 0, write-enable in bit 1 and the protection level in bits 3:2, with all other bits 0. Opcode 0x06 sets write-enable, 0x04 clears it, and 0x05 returns the status byte on the following byte.
- R3: Opcode 0x03 is followed by a 16-bit address, of which the low 12 bits are used. It returns the stored bytes from that address, incrementing after each byte and wrapping from 0xFFF to 0x000.
- R4: Opcode 0x02 is followed by a 16-bit address and data bytes. It programs the array when chip select rises, but only if write-enable was set; otherwise the array is left unchanged.
- R5: Data bytes of one write that run past a 32-byte page boundary wrap to the start of the same page.
- R6: An accepted write or status write makes status bit 0 read 1 for the busy period. Write-enable clears when the period ends. Write-enable commands, writes and status writes issued during the period are ignored.
- R7: Opcode 0x01 with a data byte loads data bits 3:2 into the protection level. Level 01 locks 0xC00–0xFFF, 10 locks 0x800–0xFFF and 11 locks the whole array. A write to a locked page is ignored, starts no busy period and leaves write-enable set.
- R8: While the write-protect input is low, a status write is ignored and starts no busy period.
- R9: Both SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) work, with data sampled on the rising SCK edge.
- R10: A write is discarded when chip select rises in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect for the status byte |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions check four things on every cycle. The array is written only inside a busy period and never at a locked address. A busy period starts only with write-enable set and leaves it cleared when it ends. The protection level changes only when write-enable is set and write-protect is released. The bench scenarios alone show the serial framing in both modes and the address increment and wrap of reads. They also show page wrap on writes, rejection while busy and the discard of a write aborted mid-byte, because each of these is only visible as the data that later comes back out of the array.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_WR_DIS = 8'h04;
  localparam logic [7:0] OP_RD_SR  = 8'h05;
  localparam logic [7:0] OP_WR_SR  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;

  typedef enum logic [2:0] {
    PH_OP,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spm_array.sv
module spm_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spm_protect.sv
module spm_protect (
  input  logic [1:0] level,
  input  logic [1:0] top_bits,  // two most significant address bits
  output logic       locked
);
  always_comb begin
    unique case (level)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &top_bits;
      2'b10:   locked = top_bits[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_prot_mem.sv
module spi_prot_mem
  import spm_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int HI_W   = ADDR_W - 8;

  // ---------------- input synchronisers ----------------
  logic [3:0] sync_q;
  logic       mosi_s, sck_s, cs_s, wp_s;
  spm_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst(rst), .d({wp_n, cs_n, sck, mosi}), .q(sync_q)
  );
  assign {wp_s, cs_s, sck_s, mosi_s} = sync_q;

  // ---------------- state ----------------
  phase_t                   phase;
  logic [2:0]               bit_cnt;
  logic [6:0]               sh_in;
  logic [7:0]               op, sh_out;
  logic [ADDR_W-1:0]        addr;
  logic                     load_pend, wel, sr_seen;
  logic [1:0]               bp, sr_data;
  logic [BUSY_W-1:0]        busy_cnt;
  logic                     committing;
  logic [PAGE_W-1:0]        commit_idx;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PAGE_BYTES-1:0]    pmask;
  logic [7:0]               pbuf [PAGE_BYTES];
  logic                     sck_q, cs_q;

  logic       sck_rise, sck_fall, cs_rise, byte_done, busy;
  logic [7:0] rx_byte, status, rd_data;
  logic       cmd_locked, wr_go, sr_go;
  logic       mem_we, wr_locked;
  logic [ADDR_W-1:0] mem_waddr;

  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign cs_rise   = cs_s & ~cs_q;
  assign byte_done = ~cs_s & sck_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {sh_in, mosi_s};
  assign busy      = (busy_cnt != '0);
  assign status    = {4'b0000, bp, wel, busy};
  assign miso      = sh_out[7];

  // ---------------- protection and array ----------------
  spm_protect u_prot_cmd (.level(bp), .top_bits(addr[ADDR_W-1 -: 2]), .locked(cmd_locked));

  assign mem_waddr = {page_q, commit_idx};
  assign mem_we    = committing & pmask[commit_idx];

  spm_protect u_prot_wr (.level(bp), .top_bits(mem_waddr[ADDR_W-1 -: 2]), .locked(wr_locked));

  spm_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[commit_idx]),
    .raddr(addr), .rdata(rd_data)
  );

  // accept decisions taken on chip-select release, only on a byte boundary
  assign wr_go = (op == OP_WRITE) && (phase == PH_DATA) && (bit_cnt == 3'd0) &&
                 (|pmask) && wel && !busy && !cmd_locked;
  assign sr_go = (op == OP_WR_SR) && sr_seen && (bit_cnt == 3'd0) &&
                 wel && !busy && wp_s;

  // page buffer, RAM style (no reset)
  always_ff @(posedge clk) begin
    if (byte_done && phase == PH_DATA && op == OP_WRITE)
      pbuf[addr[PAGE_W-1:0]] <= rx_byte;
  end

  // ---------------- protocol engine ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OP;  bit_cnt <= '0;  sh_in <= '0;  op <= '0;  addr <= '0;
      sh_out <= '0;  load_pend <= 1'b0;  wel <= 1'b0;  bp <= '0;  sr_data <= '0;
      sr_seen <= 1'b0;  busy_cnt <= '0;  committing <= 1'b0;  commit_idx <= '0;
      page_q <= '0;  pmask <= '0;  sck_q <= 1'b0;  cs_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;

      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == BUSY_W'(1)) wel <= 1'b0;
      end
      if (committing) begin
        if (commit_idx == PAGE_W'(PAGE_BYTES - 1)) committing <= 1'b0;
        commit_idx <= commit_idx + 1'b1;
      end

      if (cs_s) begin
        phase <= PH_OP;  bit_cnt <= '0;  load_pend <= 1'b0;  sr_seen <= 1'b0;
        if (cs_rise && wr_go) begin
          busy_cnt   <= BUSY_W'(BUSY_CYCLES);
          committing <= 1'b1;
          commit_idx <= '0;
          page_q     <= addr[ADDR_W-1:PAGE_W];
        end
        if (cs_rise && sr_go) begin
          busy_cnt <= BUSY_W'(BUSY_CYCLES);
          bp       <= sr_data;
        end
      end else begin
        if (sck_rise) begin
          sh_in   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            unique case (phase)
              PH_OP: begin
                op    <= rx_byte;
                phase <= PH_SKIP;
                unique case (rx_byte)
                  OP_WR_EN:  if (!busy) wel <= 1'b1;
                  OP_WR_DIS: if (!busy) wel <= 1'b0;
                  OP_RD_SR:  begin phase <= PH_DATA; load_pend <= 1'b1; end
                  OP_WR_SR:  if (!busy) phase <= PH_DATA;
                  OP_READ:   phase <= PH_AHI;
                  OP_WRITE:  if (!busy) begin phase <= PH_AHI; pmask <= '0; end
                  default: ;
                endcase
              end
              PH_AHI: begin
                addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                phase            <= PH_ALO;
              end
              PH_ALO: begin
                addr[7:0] <= rx_byte;
                phase     <= PH_DATA;
                load_pend <= (op == OP_READ);
              end
              PH_DATA: begin
                if (op == OP_WRITE) begin
                  pmask[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0]        <= addr[PAGE_W-1:0] + 1'b1;
                end else if (op == OP_WR_SR) begin
                  sr_data <= rx_byte[3:2];
                  sr_seen <= 1'b1;
                end else begin
                  load_pend <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        if (sck_fall) begin
          if (load_pend) begin
            sh_out    <= (op == OP_RD_SR) ? status : rd_data;
            load_pend <= 1'b0;
            if (op == OP_READ) addr <= addr + 1'b1;
          end else begin
            sh_out <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_wel_clear_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  assert_busy_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  assert_no_locked_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !wr_locked);

  assert_level_change_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> ($past(wel) && $past(wp_s)));
endmodule

// File: tb/test_spi_prot_mem.sv
module test_spi_prot_mem;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int BUSY       = 1500;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_prot_mem #(.ADDR_W(12), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) i_spi_prot_mem (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n), .miso(miso)
  );

  typedef struct { logic [7:0] exp; bit chk; string req; } item_t;
  item_t      q[$];
  int         tests = 0, fails = 0, nb = 0;
  bit         mode3 = 1'b0;
  logic [7:0] rx = '0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: assembles bytes on rising SCK, pops the scoreboard per byte
  initial begin
    item_t it;
    forever begin
      @(posedge sck or posedge cs_n);
      if (cs_n) nb = 0;
      else begin
        rx = {rx[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (q.size() == 0) check("scoreboard underflow", 8'h01, 8'h00);
          else begin
            it = q.pop_front();
            if (it.chk) check(it.req, rx, it.exp);
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic spi_begin();
    @(negedge clk) sck = mode3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      if (mode3) @(negedge clk) sck = 1'b0;
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string req);
    q.push_back('{exp: exp, chk: chk, req: req});
    shift_bits(tx, 8);
  endtask

  task automatic cmd(input logic [7:0] code);
    spi_begin(); xfer(code, 1'b0, 8'h00, ""); spi_end();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string req);
    spi_begin(); xfer(8'h05, 1'b0, 8'h00, ""); xfer(8'h00, 1'b1, exp, req); spi_end();
  endtask

  task automatic wrsr(input logic [7:0] val);
    spi_begin(); xfer(8'h01, 1'b0, 8'h00, ""); xfer(val, 1'b0, 8'h00, ""); spi_end();
  endtask

  task automatic write_raw(input logic [11:0] a, input int n,
                           input logic [7:0] b0, b1, b2, b3);
    logic [7:0] d[4];
    d = '{b0, b1, b2, b3};
    spi_begin();
    xfer(8'h02, 1'b0, 8'h00, "");
    xfer({4'h0, a[11:8]}, 1'b0, 8'h00, "");
    xfer(a[7:0], 1'b0, 8'h00, "");
    for (int i = 0; i < n; i++) xfer(d[i], 1'b0, 8'h00, "");
    spi_end();
  endtask

  task automatic write_en(input logic [11:0] a, input int n,
                          input logic [7:0] b0, b1, b2, b3);
    cmd(8'h06);
    write_raw(a, n, b0, b1, b2, b3);
  endtask

  task automatic read_exp(input logic [11:0] a, input int n,
                          input logic [7:0] e0, e1, e2, e3, input string req);
    logic [7:0] e[4];
    e = '{e0, e1, e2, e3};
    spi_begin();
    xfer(8'h03, 1'b0, 8'h00, "");
    xfer({4'h0, a[11:8]}, 1'b0, 8'h00, "");
    xfer(a[7:0], 1'b0, 8'h00, "");
    for (int i = 0; i < n; i++) xfer(8'h00, 1'b1, e[i], req);
    spi_end();
  endtask

  task automatic wait_idle();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    rdsr(8'h00, "R1 reset status");

    cmd(8'h06); rdsr(8'h02, "R2 enable sets bit1");
    cmd(8'h04); rdsr(8'h00, "R2 disable clears bit1");

    write_en(12'h010, 1, 8'h11, 0, 0, 0);
    rdsr(8'h03, "R6 busy and enable during cycle");
    wait_idle();
    rdsr(8'h00, "R6 idle and enable cleared after cycle");

    write_raw(12'h010, 1, 8'h55, 0, 0, 0);
    rdsr(8'h00, "R4 no busy without enable");
    read_exp(12'h010, 1, 8'h11, 0, 0, 0, "R4 unarmed write ignored");

    write_en(12'h100, 4, 8'h10, 8'h11, 8'h12, 8'h13); wait_idle();
    read_exp(12'h100, 4, 8'h10, 8'h11, 8'h12, 8'h13, "R3 sequential read");
    read_exp(12'h102, 2, 8'h12, 8'h13, 0, 0, "R3 read from offset");

    write_en(12'h21E, 4, 8'hA0, 8'hA1, 8'hA2, 8'hA3); wait_idle();
    read_exp(12'h21E, 2, 8'hA0, 8'hA1, 0, 0, "R5 page tail");
    read_exp(12'h200, 2, 8'hA2, 8'hA3, 0, 0, "R5 wrapped to page start");

    write_en(12'hFFE, 2, 8'hE0, 8'hE1, 0, 0); wait_idle();
    write_en(12'h000, 2, 8'hC0, 8'hC1, 0, 0); wait_idle();
    read_exp(12'hFFE, 4, 8'hE0, 8'hE1, 8'hC0, 8'hC1, "R3 read wraps at array end");

    write_en(12'h300, 2, 8'h30, 8'h31, 0, 0); wait_idle();
    write_en(12'h300, 1, 8'h33, 0, 0, 0);
    write_en(12'h301, 1, 8'h44, 0, 0, 0);
    rdsr(8'h03, "R6 still busy after rejected write");
    wait_idle();
    read_exp(12'h300, 2, 8'h33, 8'h31, 0, 0, "R6 write during busy ignored");

    write_en(12'hC00, 1, 8'h5A, 0, 0, 0); wait_idle();
    write_en(12'h800, 1, 8'h6B, 0, 0, 0); wait_idle();
    write_en(12'h400, 1, 8'h7C, 0, 0, 0); wait_idle();

    cmd(8'h06); wrsr(8'h04); wait_idle();
    rdsr(8'h04, "R7 level 01 stored");
    write_en(12'hC00, 1, 8'hFF, 0, 0, 0);
    rdsr(8'h06, "R7 locked write no busy, enable kept");
    write_en(12'h800, 1, 8'h81, 0, 0, 0); wait_idle();
    read_exp(12'hC00, 1, 8'h5A, 0, 0, 0, "R7 top quarter locked");
    read_exp(12'h800, 1, 8'h81, 0, 0, 0, "R7 below quarter writable");

    cmd(8'h06); wrsr(8'h08); wait_idle();
    write_en(12'h800, 1, 8'hFF, 0, 0, 0);
    write_en(12'h400, 1, 8'h44, 0, 0, 0); wait_idle();
    read_exp(12'h800, 1, 8'h81, 0, 0, 0, "R7 upper half locked");
    read_exp(12'h400, 1, 8'h44, 0, 0, 0, "R7 lower half writable");

    cmd(8'h06); wrsr(8'h0C); wait_idle();
    rdsr(8'h0C, "R7 level 11 stored");
    write_en(12'h000, 1, 8'hFF, 0, 0, 0);
    read_exp(12'h000, 1, 8'hC0, 0, 0, 0, "R7 whole array locked");

    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h00);
    rdsr(8'h0E, "R8 status write blocked by pin");
    wp_n = 1'b1;
    cmd(8'h06); wrsr(8'h00); wait_idle();
    rdsr(8'h00, "R8 status write accepted with pin high");

    mode3 = 1'b1;
    rdsr(8'h00, "R9 mode 3 status");
    read_exp(12'h100, 2, 8'h10, 8'h11, 0, 0, "R9 mode 3 read");
    write_en(12'h120, 1, 8'h9A, 0, 0, 0); wait_idle();
    mode3 = 1'b0;
    read_exp(12'h120, 1, 8'h9A, 0, 0, 0, "R9 mode 3 write read in mode 0");

    cmd(8'h06);
    spi_begin();
    xfer(8'h02, 1'b0, 8'h00, ""); xfer(8'h01, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b0, 8'h00, ""); xfer(8'h77, 1'b0, 8'h00, "");
    shift_bits(8'hEE, 4);
    spi_end();
    rdsr(8'h02, "R10 aborted write no busy");
    read_exp(12'h100, 1, 8'h10, 0, 0, 0, "R10 aborted write discarded");

    repeat (20) @(negedge clk);
    check("scoreboard drained", 8'(q.size()), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule